// File: doc/BRIEF.md
# Programmable Data and Clock Output Delay

This block sets where, inside one sample period, the output data word changes and where the rising edge of the forwarded data clock lands. It runs on a fast timing clock at sixteen ticks per sample period. A one-tick strobe marks the start of each period. At that strobe the block captures the parallel input word. It then launches the word onto its output at a tick chosen by a 3-bit data delay code. The data clock is produced in the same way from its own 3-bit code, and it stays high for half a period.

Each code gives a signed shift of up to three sixteenths of a period, in either direction. With both codes equal, the clock edge lands two ticks before the data change. An optional half-period step delays the data by a further eight ticks, but only when mux mode is off. Settings are checked before use. A reserved code is illegal. While the aligner-bypass control is set, a clock delay larger than the data delay is also illegal. Illegal settings raise a flag and are never applied. Legal settings take effect at the next period strobe.

Top module: `tdly_out`

## Requirements
- R1: While reset is low and at its release, `dout` is 0, `dclk` is 0 and `cfg_bad` is 0. The applied setting is bypass 1, half-step 0, mux 0, data code 110 and clock code 110.
- R2: The tick position is 0 on a strobe cycle, and otherwise it is the previous position plus one, modulo 16. `dout` takes the word captured at the most recent strobe edge on the edge where the position equals (5 + data steps + half) mod 16. At all other edges it holds its value.
- R3: Code decoding, in steps of one sixteenth of a period: 000=0, 001=+1, 010=+2, 011=+3, 101=-1, 110=-2, 111=-3.
- R4: `dclk` rises on the edge where the position equals 3 + clock steps, and falls eight positions later (mod 16).
- R5: With equal data and clock codes and no half-step, `dclk` rises two ticks before `dout` changes.
- R6: When half-step is 1 and mux mode is 0, the data launch position moves eight ticks later. If the launch would land at 16, it happens at position 0 of the next period, and the previous word is still the one driven.
- R7: When mux mode is 1, the half-step control has no effect on the data launch position.
- R8: Code 100 on either field is illegal. `cfg_bad` is 1 one edge after the illegal inputs appear, and the applied setting keeps its last legal value.
- R9: With bypass 1, a clock delay greater than the data delay is illegal. With bypass 0, any non-reserved pair is legal.
- R10: A legal input setting clears `cfg_bad` on the next edge, and it is applied at the next strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, 16 ticks per sample period |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-tick strobe at the start of each sample period |
| din | input | W | Parallel data word, captured at the strobe |
| mux_mode | input | 1 | Mux mode flag; suppresses the half-period step |
| aln_bypass | input | 1 | Aligner bypass; enables the clock-not-after-data legality rule |
| half_dly | input | 1 | Request for an extra half-period data delay |
| dat_code | input | 3 | Data delay code |
| clk_code | input | 3 | Data clock delay code |
| dout | output | W | Delayed data word |
| dclk | output | 1 | Delayed data clock |
| cfg_bad | output | 1 | Illegal setting flag |

## Verification
The launch-timing assertions relate output changes to the tick position and offsets computed by separate pieces of logic. They assume the strobe repeats exactly every sixteen ticks, so a launch at offset sixteen reuses the captured word correctly. The stimulus therefore drives the strobe from a free-running counter that is never disturbed. Control fields change at arbitrary ticks, including mid-period and across illegal values. This is safe because the applied setting only moves at strobe edges.

// File: rtl/tdly_pkg.sv
package tdly_pkg;

   typedef logic [2:0] dcode_t;

   typedef struct packed {
      logic   byp;
      logic   half;
      logic   mux;
      dcode_t dc;
      dcode_t cc;
   } tcfg_t;

   localparam tcfg_t CFG_RST = '{byp: 1'b1, half: 1'b0, mux: 1'b0,
                                 dc: 3'b110, cc: 3'b110};

   localparam dcode_t CODE_RSVD = 3'b100;

   // signed step count of a delay code (reserved code reads as zero)
   function automatic logic signed [3:0] code_steps(input dcode_t c);
      logic signed [3:0] s;
      case (c)
         3'b001:  s = 4'sd1;
         3'b010:  s = 4'sd2;
         3'b011:  s = 4'sd3;
         3'b101:  s = -4'sd1;
         3'b110:  s = -4'sd2;
         3'b111:  s = -4'sd3;
         default: s = 4'sd0;
      endcase
      return s;
   endfunction

   function automatic logic cfg_legal(input tcfg_t c);
      logic ok;
      ok = (c.dc != CODE_RSVD) && (c.cc != CODE_RSVD);
      if (c.byp && (code_steps(c.cc) > code_steps(c.dc)))
         ok = 1'b0;
      return ok;
   endfunction

endpackage

// File: rtl/tdly_cfg_guard.sv
module tdly_cfg_guard
   import tdly_pkg::*;
#(
   parameter bit LOAD_AT_STROBE = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  strobe,
   input  tcfg_t req,
   output tcfg_t act,
   output logic  bad
);

   logic legal;
   logic load;

   assign legal = cfg_legal(req);

   generate
      if (LOAD_AT_STROBE) begin : g_sync_load
         assign load = legal & strobe;
      end else begin : g_free_load
         assign load = legal;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act <= CFG_RST;
         bad <= 1'b0;
      end else begin
         bad <= ~legal;
         if (load)
            act <= req;
      end
   end

endmodule

// File: rtl/tdly_phase.sv
module tdly_phase #(
   parameter int PHASES = 16,
   localparam int PW    = $clog2(PHASES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strobe,
   output logic [PW-1:0] pos
);

   logic [PW-1:0] age;

   assign pos = strobe ? '0 : PW'(age + 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         age <= '0;
      else
         age <= pos;
   end

endmodule

// File: rtl/tdly_launch.sv
module tdly_launch
   import tdly_pkg::*;
#(
   parameter int W        = 10,
   parameter int PHASES   = 16,
   parameter int CLK_BASE = 3,
   parameter int GAP      = 2,
   localparam int PW      = $clog2(PHASES),
   localparam int HALF    = PHASES / 2,
   localparam int DAT_BASE = CLK_BASE + GAP
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strobe,
   input  logic [W-1:0]  din,
   input  logic [PW-1:0] pos,
   input  tcfg_t         act,
   output logic [PW-1:0] dat_off,
   output logic [PW-1:0] clk_off,
   output logic [W-1:0]  dout,
   output logic          dclk
);

   logic [W-1:0]  cap;
   logic [PW-1:0] clk_fall;
   int            d_ticks;
   int            c_ticks;

   always_comb begin
      c_ticks = CLK_BASE + int'(code_steps(act.cc));
      d_ticks = DAT_BASE + int'(code_steps(act.dc));
      if (act.half && !act.mux)
         d_ticks = d_ticks + HALF;
      clk_off  = PW'(c_ticks);
      dat_off  = PW'(d_ticks);
      clk_fall = PW'(c_ticks + HALF);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap  <= '0;
         dout <= '0;
         dclk <= 1'b0;
      end else begin
         if (strobe)
            cap <= din;
         if (pos == dat_off)
            dout <= cap;
         if (pos == clk_off)
            dclk <= 1'b1;
         else if (pos == clk_fall)
            dclk <= 1'b0;
      end
   end

endmodule

// File: rtl/tdly_out.sv
module tdly_out
   import tdly_pkg::*;
#(
   parameter int W              = 10,
   parameter int PHASES         = 16,
   parameter bit LOAD_AT_STROBE = 1'b1,
   localparam int PW            = $clog2(PHASES)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         smp_stb,
   input  logic [W-1:0] din,
   input  logic         mux_mode,
   input  logic         aln_bypass,
   input  logic         half_dly,
   input  logic [2:0]   dat_code,
   input  logic [2:0]   clk_code,
   output logic [W-1:0] dout,
   output logic         dclk,
   output logic         cfg_bad
);

   generate
      if (PHASES != 16) begin : g_chk_phases
         $error("tdly_out: codes are in sixteenths, PHASES must be 16");
      end
      if (W < 1) begin : g_chk_width
         $error("tdly_out: W must be at least 1");
      end
   endgenerate

   tcfg_t         req_w;
   tcfg_t         act_w;
   logic [PW-1:0] pos_w;
   logic [PW-1:0] dat_off_w;
   logic [PW-1:0] clk_off_w;

   assign req_w = '{byp: aln_bypass, half: half_dly, mux: mux_mode,
                    dc: dat_code, cc: clk_code};

   tdly_cfg_guard #(.LOAD_AT_STROBE(LOAD_AT_STROBE)) u_guard (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (smp_stb),
      .req    (req_w),
      .act    (act_w),
      .bad    (cfg_bad)
   );

   tdly_phase #(.PHASES(PHASES)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (smp_stb),
      .pos    (pos_w)
   );

   tdly_launch #(.W(W), .PHASES(PHASES)) u_launch (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (smp_stb),
      .din     (din),
      .pos     (pos_w),
      .act     (act_w),
      .dat_off (dat_off_w),
      .clk_off (clk_off_w),
      .dout    (dout),
      .dclk    (dclk)
   );

endmodule

// File: rtl/tdly_out_chk.sv
module tdly_out_chk
   import tdly_pkg::*;
#(
   parameter int W  = 10,
   parameter int PW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [W-1:0]  dout,
   input logic          dclk,
   input logic [PW-1:0] pos,
   input logic [PW-1:0] dat_off,
   input logic [PW-1:0] clk_off,
   input logic          act_byp,
   input logic [2:0]    act_dc,
   input logic [2:0]    act_cc
);

   localparam logic [PW-1:0] HALFP = PW'(1 << (PW - 1));

   // R2
   dout_moves_on_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout) |-> $past(pos == dat_off));

   // R4
   dclk_rises_on_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dclk) |-> $past(pos == clk_off));

   // R4
   dclk_falls_half_later_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dclk) |-> $past(pos == PW'(clk_off + HALFP)));

   // R8
   no_reserved_applied_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_dc != CODE_RSVD) && (act_cc != CODE_RSVD));

   // R9
   bypass_order_applied_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_byp |-> (code_steps(act_cc) <= code_steps(act_dc)));

endmodule

bind tdly_out tdly_out_chk #(.W(W), .PW(PW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .dout    (dout),
   .dclk    (dclk),
   .pos     (pos_w),
   .dat_off (dat_off_w),
   .clk_off (clk_off_w),
   .act_byp (act_w.byp),
   .act_dc  (act_w.dc),
   .act_cc  (act_w.cc)
);

// File: tb/tdly_out_test.sv
module tdly_out_test;

   localparam int W = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         smp_stb = 1'b0;
   logic [W-1:0] din = '0;
   logic         mux_mode = 1'b0;
   logic         aln_bypass = 1'b1;
   logic         half_dly = 1'b0;
   logic [2:0]   dat_code = 3'b110;
   logic [2:0]   clk_code = 3'b110;
   logic [W-1:0] dout;
   logic         dclk;
   logic         cfg_bad;

   always #5 clk = ~clk;

   tdly_out #(.W(W)) uut (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .din(din),
      .mux_mode(mux_mode), .aln_bypass(aln_bypass), .half_dly(half_dly),
      .dat_code(dat_code), .clk_code(clk_code),
      .dout(dout), .dclk(dclk), .cfg_bad(cfg_bad)
   );

   int    total = 0;
   int    bad = 0;
   string tag = "R1";
   int    scnt = 15;
   logic [W-1:0] lfsr = 10'h2a5;

   // R3: behavioural code table
   function automatic int steps(input logic [2:0] c);
      case (c)
         3'd1: return 1;
         3'd2: return 2;
         3'd3: return 3;
         3'd5: return -1;
         3'd6: return -2;
         3'd7: return -3;
         default: return 0;
      endcase
   endfunction

   function automatic bit ok_pair(input bit byp, input logic [2:0] d, input logic [2:0] c);
      if (d == 3'd4 || c == 3'd4) return 1'b0;
      if (byp && steps(c) > steps(d)) return 1'b0;
      return 1'b1;
   endfunction

   // reference model state
   int           m_age;
   logic [W-1:0] m_cap, m_dout;
   bit           m_dclk, m_bad;
   bit           a_byp, a_half, a_mux;
   logic [2:0]   a_dc, a_cc;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_age = 0; m_cap = '0; m_dout = '0; m_dclk = 0; m_bad = 0;
         a_byp = 1; a_half = 0; a_mux = 0; a_dc = 3'b110; a_cc = 3'b110;
      end else begin
         int p, doff, coff;
         p = smp_stb ? 0 : (m_age + 1) % 16;
         coff = 3 + steps(a_cc);
         doff = (5 + steps(a_dc) + ((a_half && !a_mux) ? 8 : 0)) % 16;
         if (p == doff) m_dout = m_cap;
         if (p == coff) m_dclk = 1;
         else if (p == (coff + 8) % 16) m_dclk = 0;
         if (smp_stb) m_cap = din;
         m_bad = !ok_pair(aln_bypass, dat_code, clk_code);
         if (smp_stb && !m_bad) begin
            a_byp = aln_bypass; a_half = half_dly; a_mux = mux_mode;
            a_dc = dat_code; a_cc = clk_code;
         end
         m_age = p;
      end
   end

   task automatic check_now();
      total++;
      if (dout !== m_dout || dclk !== m_dclk || cfg_bad !== m_bad) begin
         bad++;
         $display("FAIL %s t=%0t dout/dclk/bad actual=%h/%b/%b expected=%h/%b/%b",
                  tag, $time, dout, dclk, cfg_bad, m_dout, m_dclk, m_bad);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (rst_n) check_now();
         scnt = (scnt + 1) % 16;
         smp_stb = (scnt == 0);
         if (smp_stb) begin
            lfsr = {lfsr[W-2:0], lfsr[9] ^ lfsr[6]};
            din = lfsr;
         end
      end
   endtask

   task automatic setc(input bit byp, input bit half, input bit mux,
                       input logic [2:0] d, input logic [2:0] c);
      aln_bypass = byp; half_dly = half; mux_mode = mux;
      dat_code = d; clk_code = c;
   endtask

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      step(3);
      @(negedge clk);
      // R1: reset state
      tag = "R1";
      total++;
      if (dout !== '0 || dclk !== 1'b0 || cfg_bad !== 1'b0) begin
         bad++;
         $display("FAIL R1 reset actual=%h/%b/%b expected=0/0/0", dout, dclk, cfg_bad);
      end
      rst_n = 1'b1;
      step(1);
      tag = "R1";
      step(40);
      tag = "R2";
      step(64);
      // R3: every non-reserved pair without the bypass rule
      tag = "R3";
      foreach (lfsr[k]) begin end
      for (int di = 0; di < 8; di++) begin
         for (int ci = 0; ci < 8; ci++) begin
            if (di == 4 || ci == 4) continue;
            setc(0, 0, 0, 3'(di), 3'(ci));
            step(37);
         end
      end
      // R4 / R5: equal codes with bypass on
      tag = "R5";
      for (int di = 0; di < 8; di++) begin
         if (di == 4) continue;
         setc(1, 0, 0, 3'(di), 3'(di));
         step(40);
      end
      tag = "R4";
      setc(1, 0, 0, 3'b011, 3'b111);
      step(40);
      // R6: half-step, including launch wrapping to position 0
      tag = "R6";
      setc(1, 1, 0, 3'b011, 3'b011);
      step(48);
      setc(1, 1, 0, 3'b111, 3'b111);
      step(48);
      // R7: mux mode suppresses the half-step
      tag = "R7";
      setc(1, 1, 1, 3'b011, 3'b001);
      step(48);
      // R8: reserved codes
      tag = "R8";
      setc(0, 0, 0, 3'b100, 3'b000);
      step(40);
      setc(0, 0, 0, 3'b010, 3'b100);
      step(40);
      // R9: clock later than data
      tag = "R9";
      setc(1, 0, 0, 3'b000, 3'b011);
      step(40);
      setc(0, 0, 0, 3'b000, 3'b011);
      step(40);
      // R10: recovery mid-period
      tag = "R10";
      setc(1, 0, 0, 3'b100, 3'b100);
      step(21);
      setc(1, 0, 0, 3'b001, 3'b101);
      step(40);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule